// File: doc/BRIEF.md
# OTP Fuse Word Programmer

This block lets software burn one 32-bit word of a one-time-programmable fuse array per request and refresh a small bank of shadow copies of the fuses. Software drives it through a flat register bus with a 5-bit offset. A control register holds the target word address and a 16-bit unlock field. It also reports three status flags: operation in progress, sticky error and reload in progress. Separate set and clear alias offsets start a shadow reload and clear the error. Four data registers cover one fuse bank of four words. The low two address bits pick which data register supplies the word, and a write to data register 0 always triggers the burn.

Once a write is accepted, the target address is frozen in an internal latch. The controller reads the current fuse word and removes from the new data every bit that is already blown. It then shifts the result out LSB first, one bit per cycle, and pulses the fuse-blow port only for bits that are 1. The source data register drains to zero as it shifts. A timed recovery window follows every burn, and the block counts as busy throughout it. A request aimed at a bank marked in the lock bitmap never touches the fuses and raises a sticky error instead.

Top module: `otp_fuse_prog`

## Requirements
- R1: After reset the control register (offset 0x00), the four data registers (0x04..0x07) and all shadow registers (0x10..0x17) read zero.
- R2: A write to offset 0x04 while idle and error-free starts a burn when control bits [31:16] hold 0x3E77. In the cycle after that write, BUSY (control bit 8) reads 1 and the unlock field reads 0.
- R3: Each burn pulses fuseBlow only for bits set in the data and clear in the current fuse word, in ascending bit order, at the latched address. The fuse word then equals old OR new.
- R4: After a burn completes, the data register that supplied the word reads zero.
- R5: Address writes to the control register during a burn do not redirect it. The new address reads back afterwards.
- R6: A write to offset 0x04 without the correct unlock code starts nothing: BUSY stays 0 and no fuse changes.
- R7: Writes to any data register while BUSY is 1 are ignored.
- R8: If lockMap bit (address >> 2) is 1, an unlocked start sets ERROR (control bit 9), leaves BUSY at 0 and blows nothing. While ERROR is 1, further unlocked starts are ignored.
- R9: ERROR clears only when bit 9 is written as 1 at the clear alias (offset 0x02). Other bits written there leave it set.
- R10: Address bits [1:0] select data register 0x04+n as the word source. Writes to 0x05..0x07 never start a burn.
- R11: BUSY stays 1 for exactly 1 + 32 + POST_CYCLES cycles per burn (533 at the default 250 MHz and 2 us). A start issued during the recovery window is ignored.
- R12: Writing 1 to bit 10 at the set alias (offset 0x01) copies fuse words 0..7 into shadow registers 0x10..0x17. Control bits 10 and 8 read 1 for the 8 cycles this takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Register offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| lockMap | input | 16 | One lock bit per four-word bank |
| fuseAddr | output | 6 | Fuse word address for reads and blows |
| fuseRdEn | output | 1 | Fuse read cycle (verify or reload) |
| fuseRdData | input | 32 | Fuse word at fuseAddr, same cycle |
| fuseBlow | output | 1 | Blow the bit fuseBitIdx of word fuseAddr |
| fuseBitIdx | output | 5 | Bit position being programmed |

## Verification
Burns are run on a blank word and on a partly blown word. The second case separates correct masking from blind programming, because every stray pulse on a blown bit lands in the scoreboard as an unexpected item. One burn is sourced from a non-zero word slot while the address is rewritten mid-burn. This separates the latched address from the live field and the selected data register from data register 0. Ignored-start cases cover a missing key, a locked bank, a pending error and a start during the recovery window. Each of them is told apart from an accepted start by the BUSY flag and by the fuse contents.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 5;
  localparam int KEY_W  = 16;

  localparam logic [OFS_W-1:0] OFS_CTRL   = 5'h00;
  localparam logic [OFS_W-1:0] OFS_SET    = 5'h01;
  localparam logic [OFS_W-1:0] OFS_CLR    = 5'h02;
  localparam logic [OFS_W-1:0] OFS_DATA   = 5'h04;
  localparam logic [OFS_W-1:0] OFS_SHADOW = 5'h10;

  localparam int BUSY_BIT   = 8;
  localparam int ERR_BIT    = 9;
  localparam int RELOAD_BIT = 10;
  localparam int KEY_LSB    = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_PROG, ST_POST, ST_RELOAD
  } stateT;

  typedef struct packed {
    logic latchAddr;
    logic clrKey;
    logic loadMask;
    logic shiftOut;
    logic loadShadow;
  } dpStrobeT;
endpackage

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int NUM_SHADOW  = 8,
  parameter int POST_CYCLES = 500,
  localparam int SH_W  = $clog2(NUM_SHADOW),
  localparam int BIT_W = $clog2(WORD_W),
  localparam int PC_W  = $clog2(POST_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             reloadReq,
  input  logic             errClrReq,
  input  logic             keyOk,
  input  logic             bankLocked,
  output dpStrobeT         strobe,
  output logic             busy,
  output logic             errorFlag,
  output logic             reloading,
  output logic [SH_W-1:0]  shadowIdx,
  output logic [BIT_W-1:0] bitIdx
);
  stateT state;
  logic [PC_W-1:0] postCnt;
  logic startOk;

  // a start is honoured only from idle with a valid key and no pending error
  assign startOk = (state == ST_IDLE) && startReq && keyOk && !errorFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      errorFlag <= 1'b0;
      postCnt   <= '0;
      bitIdx    <= '0;
      shadowIdx <= '0;
    end else begin
      if (errClrReq) errorFlag <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startOk) begin
            if (bankLocked) errorFlag <= 1'b1;
            else            state     <= ST_READ;
          end else if (reloadReq) begin
            state     <= ST_RELOAD;
            shadowIdx <= '0;
          end
        end
        ST_READ: begin
          state  <= ST_PROG;
          bitIdx <= '0;
        end
        ST_PROG: begin
          bitIdx <= bitIdx + 1'b1;
          if (bitIdx == BIT_W'(WORD_W - 1)) begin
            state   <= ST_POST;
            postCnt <= PC_W'(POST_CYCLES - 1);
          end
        end
        ST_POST: begin
          if (postCnt == '0) state <= ST_IDLE;
          else               postCnt <= postCnt - 1'b1;
        end
        ST_RELOAD: begin
          shadowIdx <= shadowIdx + 1'b1;
          if (shadowIdx == SH_W'(NUM_SHADOW - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.latchAddr  = startOk && !bankLocked;
    strobe.clrKey     = (state == ST_IDLE) && startReq;
    strobe.loadMask   = (state == ST_READ);
    strobe.shiftOut   = (state == ST_PROG);
    strobe.loadShadow = (state == ST_RELOAD);
  end

  assign busy      = (state != ST_IDLE);
  assign reloading = (state == ST_RELOAD);
endmodule

// File: rtl/otp_fuse_datapath.sv
module otp_fuse_datapath
  import otp_fuse_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          BANK_WORDS = 4,
  parameter int          NUM_SHADOW = 8,
  parameter logic [15:0] UNLOCK_KEY = 16'h3E77,
  localparam int BANK_W    = $clog2(BANK_WORDS),
  localparam int SH_W      = $clog2(NUM_SHADOW),
  localparam int NUM_BANKS = (2 ** ADDR_W) / BANK_WORDS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OFS_W-1:0]     regAddr,
  input  logic                 regWrEn,
  input  logic [WORD_W-1:0]    regWrData,
  output logic [WORD_W-1:0]    regRdData,
  input  logic [NUM_BANKS-1:0] lockMap,
  input  dpStrobeT             strobe,
  input  logic                 busy,
  input  logic                 errorFlag,
  input  logic                 reloading,
  input  logic [SH_W-1:0]      shadowIdx,
  input  logic [WORD_W-1:0]    fuseRdData,
  output logic                 keyOk,
  output logic                 bankLocked,
  output logic                 pgmBit,
  output logic [ADDR_W-1:0]    fuseAddr
);
  logic [ADDR_W-1:0] addrField;
  logic [KEY_W-1:0]  keyField;
  logic [ADDR_W-1:0] opAddr;
  logic [WORD_W-1:0] dataRegs   [BANK_WORDS];
  logic [WORD_W-1:0] shadowRegs [NUM_SHADOW];
  logic [BANK_W-1:0] opWord;
  logic              ctrlHit, dataHit, shadowHit;

  assign ctrlHit   = (regAddr == OFS_CTRL);
  assign dataHit   = (regAddr[OFS_W-1:BANK_W] == OFS_DATA[OFS_W-1:BANK_W]);
  assign shadowHit = (regAddr[OFS_W-1:SH_W] == OFS_SHADOW[OFS_W-1:SH_W]);
  assign opWord    = opAddr[BANK_W-1:0];

  // control fields: address is live, key is consumed by every idle start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrField <= '0;
      keyField  <= '0;
      opAddr    <= '0;
    end else begin
      if (regWrEn && ctrlHit) begin
        addrField <= regWrData[ADDR_W-1:0];
        keyField  <= regWrData[KEY_LSB +: KEY_W];
      end else if (strobe.clrKey) begin
        keyField <= '0;
      end
      if (strobe.latchAddr) opAddr <= addrField;
    end
  end

  // data registers: software writes when idle, mask and shift when busy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BANK_WORDS; i++) dataRegs[i] <= '0;
    end else if (!busy) begin
      if (regWrEn && dataHit) dataRegs[regAddr[BANK_W-1:0]] <= regWrData;
    end else if (strobe.loadMask) begin
      dataRegs[opWord] <= dataRegs[opWord] & ~fuseRdData;
    end else if (strobe.shiftOut) begin
      dataRegs[opWord] <= {1'b0, dataRegs[opWord][WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SHADOW; i++) shadowRegs[i] <= '0;
    end else if (strobe.loadShadow) begin
      shadowRegs[shadowIdx] <= fuseRdData;
    end
  end

  assign keyOk      = (keyField == UNLOCK_KEY);
  assign bankLocked = lockMap[addrField[ADDR_W-1:BANK_W]];
  assign pgmBit     = dataRegs[opWord][0];
  assign fuseAddr   = reloading ? ADDR_W'(shadowIdx) : opAddr;

  always_comb begin
    regRdData = '0;
    if (ctrlHit) begin
      regRdData[ADDR_W-1:0]         = addrField;
      regRdData[BUSY_BIT]           = busy;
      regRdData[ERR_BIT]            = errorFlag;
      regRdData[RELOAD_BIT]         = reloading;
      regRdData[KEY_LSB +: KEY_W]   = keyField;
    end else if (dataHit) begin
      regRdData = dataRegs[regAddr[BANK_W-1:0]];
    end else if (shadowHit) begin
      regRdData = shadowRegs[regAddr[SH_W-1:0]];
    end
  end
endmodule

// File: rtl/otp_fuse_prog.sv
module otp_fuse_prog
  import otp_fuse_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          BANK_WORDS = 4,
  parameter int          NUM_SHADOW = 8,
  parameter int          CLK_MHZ    = 250,
  parameter int          POST_NS    = 2000,
  parameter logic [15:0] UNLOCK_KEY = 16'h3E77,
  localparam int NUM_BANKS   = (2 ** ADDR_W) / BANK_WORDS,
  localparam int BIT_W       = $clog2(WORD_W),
  localparam int SH_W        = $clog2(NUM_SHADOW),
  localparam int POST_CYCLES = (CLK_MHZ * POST_NS) / 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OFS_W-1:0]     regAddr,
  input  logic                 regWrEn,
  input  logic [WORD_W-1:0]    regWrData,
  output logic [WORD_W-1:0]    regRdData,
  input  logic [NUM_BANKS-1:0] lockMap,
  output logic [ADDR_W-1:0]    fuseAddr,
  output logic                 fuseRdEn,
  input  logic [WORD_W-1:0]    fuseRdData,
  output logic                 fuseBlow,
  output logic [BIT_W-1:0]     fuseBitIdx
);
  dpStrobeT        strobe;
  logic            busyFlag, errorFlag, reloading;
  logic            keyOk, bankLocked, pgmBit;
  logic            startReq, reloadReq, errClrReq;
  logic [SH_W-1:0] shadowIdx;

  assign startReq  = regWrEn && (regAddr == OFS_DATA);
  assign reloadReq = regWrEn && (regAddr == OFS_SET) && regWrData[RELOAD_BIT];
  assign errClrReq = regWrEn && (regAddr == OFS_CLR) && regWrData[ERR_BIT];

  otp_fuse_ctrl #(
    .NUM_SHADOW (NUM_SHADOW),
    .POST_CYCLES(POST_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .reloadReq (reloadReq),
    .errClrReq (errClrReq),
    .keyOk     (keyOk),
    .bankLocked(bankLocked),
    .strobe    (strobe),
    .busy      (busyFlag),
    .errorFlag (errorFlag),
    .reloading (reloading),
    .shadowIdx (shadowIdx),
    .bitIdx    (fuseBitIdx)
  );

  otp_fuse_datapath #(
    .ADDR_W    (ADDR_W),
    .BANK_WORDS(BANK_WORDS),
    .NUM_SHADOW(NUM_SHADOW),
    .UNLOCK_KEY(UNLOCK_KEY)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .lockMap   (lockMap),
    .strobe    (strobe),
    .busy      (busyFlag),
    .errorFlag (errorFlag),
    .reloading (reloading),
    .shadowIdx (shadowIdx),
    .fuseRdData(fuseRdData),
    .keyOk     (keyOk),
    .bankLocked(bankLocked),
    .pgmBit    (pgmBit),
    .fuseAddr  (fuseAddr)
  );

  assign fuseRdEn = strobe.loadMask | strobe.loadShadow;
  assign fuseBlow = strobe.shiftOut & pgmBit;
endmodule

// File: rtl/otp_fuse_prog_sva.sv
module otp_fuse_prog_sva #(
  parameter int ADDR_W     = 6,
  parameter int BANK_WORDS = 4,
  localparam int BANK_W    = $clog2(BANK_WORDS),
  localparam int NUM_BANKS = (2 ** ADDR_W) / BANK_WORDS
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 fuseBlow,
  input logic [ADDR_W-1:0]    fuseAddr,
  input logic [NUM_BANKS-1:0] lockMap,
  input logic                 busy,
  input logic                 errorFlag,
  input logic                 errClrReq
);
  // R3: a blow pulse only ever happens inside a busy operation
  assert_blow_in_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    fuseBlow |-> busy);

  // R5: consecutive blow pulses keep the same latched address
  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fuseBlow && $past(fuseBlow)) |-> $stable(fuseAddr));

  // R8: no blow lands in a locked bank
  assert_lock_no_blow_R8: assert property (@(posedge clk) disable iff (!rstN)
    fuseBlow |-> !lockMap[fuseAddr[ADDR_W-1:BANK_W]]);

  // R8: a rising error never comes with a started operation
  assert_err_no_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errorFlag) |-> !busy);

  // R9: error drops only after a clear-alias write of its bit
  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errorFlag) |-> $past(errClrReq));
endmodule

bind otp_fuse_prog otp_fuse_prog_sva #(
  .ADDR_W    (ADDR_W),
  .BANK_WORDS(BANK_WORDS)
) u_sva (
  .clk      (clk),
  .rstN     (rstN),
  .fuseBlow (fuseBlow),
  .fuseAddr (fuseAddr),
  .lockMap  (lockMap),
  .busy     (busyFlag),
  .errorFlag(errorFlag),
  .errClrReq(errClrReq)
);

// File: tb/otp_fuse_prog_bench.sv
module otp_fuse_prog_bench;
  import otp_fuse_pkg::*;

  localparam int          NWORDS    = 64;
  localparam int          NSHADOW   = 8;
  localparam int          POST_CYC  = 500;
  localparam logic [15:0] KEY       = 16'h3E77;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [15:0] lockMap;
  logic [5:0]  fuseAddr;
  logic        fuseRdEn;
  logic [31:0] fuseRdData;
  logic        fuseBlow;
  logic [4:0]  fuseBitIdx;

  logic [31:0] fuseMem [NWORDS];
  int checks = 0;
  int failures = 0;
  int expQ[$];
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 4 time units per period: 250 MHz at 1 ns units

  otp_fuse_prog u_otp_fuse_prog (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .lockMap   (lockMap),
    .fuseAddr  (fuseAddr),
    .fuseRdEn  (fuseRdEn),
    .fuseRdData(fuseRdData),
    .fuseBlow  (fuseBlow),
    .fuseBitIdx(fuseBitIdx)
  );

  // behavioural fuse array: preset pattern on reset, bits only ever set
  assign fuseRdData = fuseMem[fuseAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NWORDS; i++) fuseMem[i] <= 32'(i) * 32'h11;
    end else if (fuseBlow) begin
      fuseMem[fuseAddr][fuseBitIdx] <= 1'b1;
    end
  end

  // monitor: every blow pulse pops one expected (address, bit) item
  always @(negedge clk) begin
    int got;
    int want;
    if (rstN && fuseBlow) begin
      got = int'(fuseAddr) * 32 + int'(fuseBitIdx);
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R3 unexpected blow act=%0d exp=none", got);
      end else begin
        want = expQ.pop_front();
        if (got != want) begin
          failures++;
          $display("FAIL R3 blow position act=%0d exp=%0d", got, want);
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr   = a;
    regWrData = d;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic regRead(logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pushExpect(int addr, logic [31:0] data);
    for (int b = 0; b < 32; b++)
      if (data[b] && !fuseMem[addr][b]) expQ.push_back(addr * 32 + b);
  endtask

  // driver: arm, place word in its slot, start via slot 0
  task automatic doProgram(int addr, logic [31:0] data, bit expectRun);
    int sel;
    sel = addr % 4;
    regWrite(OFS_CTRL, {KEY, 16'(addr)});
    if (expectRun) pushExpect(addr, data);
    if (sel != 0) begin
      regWrite(5'(int'(OFS_DATA) + sel), data);
      regWrite(OFS_DATA, 32'h0);
    end else begin
      regWrite(OFS_DATA, data);
    end
  endtask

  task automatic waitIdle(output int cyc);
    logic [31:0] r;
    cyc = 0;
    for (int k = 0; k < 5000; k++) begin
      regRead(OFS_CTRL, r);
      if (!r[BUSY_BIT]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    int stallCnt;
    for (int k = 0; k < 200000; k++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    stallCnt = 0;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] old;
    int cyc;
    rstN      = 1'b0;
    regAddr   = '0;
    regWrEn   = 1'b0;
    regWrData = '0;
    lockMap   = 16'h0008;  // bank 3: words 12..15
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(OFS_CTRL, r);           chk("R1 ctrl", r, 32'h0);
    for (int n = 0; n < 4; n++) begin
      regRead(5'(int'(OFS_DATA) + n), r); chk("R1 data", r, 32'h0);
    end
    regRead(OFS_SHADOW, r);         chk("R1 shadow", r, 32'h0);

    // R2 R11 R3 R4: blank word, slot 0
    doProgram(0, 32'hA5A5_0001, 1'b1);
    regRead(OFS_CTRL, r);
    chk("R2 busy after start", 32'(r[BUSY_BIT]), 32'h1);
    chk("R2 key consumed", 32'(r[31:16]), 32'h0);
    waitIdle(cyc);
    chk("R11 busy length", 32'(cyc), 32'(1 + 32 + POST_CYC));
    chk("R3 blank word", fuseMem[0], 32'hA5A5_0001);
    regRead(OFS_DATA, r);           chk("R4 slot drained", r, 32'h0);

    // R3 R5 R7 R10: partly blown word from slot 1, address moved mid-burn
    old = fuseMem[9];
    doProgram(5, 32'hFF00_00FF, 1'b1);
    regWrite(OFS_CTRL, 32'h0000_0009);
    regWrite(5'(int'(OFS_DATA) + 2), 32'h0000_1234);
    waitIdle(cyc);
    chk("R3 masked word", fuseMem[5], 32'hFF00_00FF | 32'h55);
    chk("R5 other word untouched", fuseMem[9], old);
    regRead(OFS_CTRL, r);           chk("R5 new address readback", 32'(r[5:0]), 32'h9);
    regRead(5'(int'(OFS_DATA) + 2), r); chk("R7 busy write ignored", r, 32'h0);
    regRead(5'(int'(OFS_DATA) + 1), r); chk("R10 R4 slot1 drained", r, 32'h0);

    // R6: missing and wrong key
    old = fuseMem[2];
    regWrite(OFS_CTRL, 32'h0000_0002);
    regWrite(OFS_DATA, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    regRead(OFS_CTRL, r);           chk("R6 no key no busy", 32'(r[BUSY_BIT]), 32'h0);
    regWrite(OFS_CTRL, 32'h1111_0002);
    regWrite(OFS_DATA, 32'hFFFF_FFFF);
    regRead(OFS_CTRL, r);           chk("R6 wrong key no busy", 32'(r[BUSY_BIT]), 32'h0);
    chk("R6 word untouched", fuseMem[2], old);

    // R10: slot 2 write alone does not start, slot 0 does
    regWrite(OFS_CTRL, {KEY, 16'd6});
    regWrite(5'(int'(OFS_DATA) + 2), 32'h0000_00F0);
    repeat (2) @(negedge clk);
    regRead(OFS_CTRL, r);           chk("R10 slot2 no start", 32'(r[BUSY_BIT]), 32'h0);
    old = fuseMem[6];
    pushExpect(6, 32'h0000_00F0);
    regWrite(OFS_DATA, 32'h0);
    waitIdle(cyc);
    chk("R10 word from slot2", fuseMem[6], old | 32'h0000_00F0);

    // R8 R9: locked bank, pending error, clear alias
    old = fuseMem[13];
    doProgram(13, 32'h0000_00FF, 1'b0);
    regRead(OFS_CTRL, r);
    chk("R8 error set", 32'(r[ERR_BIT]), 32'h1);
    chk("R8 not busy", 32'(r[BUSY_BIT]), 32'h0);
    chk("R8 locked word untouched", fuseMem[13], old);
    old = fuseMem[1];
    doProgram(1, 32'h0000_FF00, 1'b0);
    regRead(OFS_CTRL, r);           chk("R8 start blocked by error", 32'(r[BUSY_BIT]), 32'h0);
    chk("R8 word untouched", fuseMem[1], old);
    regWrite(OFS_CLR, 32'h0000_0100);
    regRead(OFS_CTRL, r);           chk("R9 other bit no clear", 32'(r[ERR_BIT]), 32'h1);
    regWrite(OFS_CLR, 32'h0000_0200);
    regRead(OFS_CTRL, r);           chk("R9 error cleared", 32'(r[ERR_BIT]), 32'h0);

    // R11: start during recovery window is ignored
    doProgram(3, 32'h0000_0100, 1'b1);
    repeat (40) @(negedge clk);
    old = fuseMem[4];
    regWrite(OFS_CTRL, {KEY, 16'd4});
    regWrite(OFS_DATA, 32'h0000_00FF);
    waitIdle(cyc);
    chk("R11 postamble start ignored", fuseMem[4], old);
    chk("R3 word 3", fuseMem[3], 32'h33 | 32'h100);
    regWrite(OFS_CTRL, 32'h0);

    // R12: shadow reload
    regWrite(OFS_SET, 32'h0000_0400);
    regRead(OFS_CTRL, r);
    chk("R12 reload flag", 32'(r[RELOAD_BIT]), 32'h1);
    chk("R12 busy during reload", 32'(r[BUSY_BIT]), 32'h1);
    waitIdle(cyc);
    chk("R12 reload length", 32'(cyc), 32'(NSHADOW));
    for (int i = 0; i < NSHADOW; i++) begin
      regRead(5'(int'(OFS_SHADOW) + i), r);
      chk("R12 shadow copy", r, fuseMem[i]);
    end

    chk("R3 scoreboard drained", 32'(expQ.size()), 32'h0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule